// File: doc/BRIEF.md
# Wake Event Status Controller

This block gathers wake sources into sticky status registers and drives one registered, active-low wake request. The sources are the keyboard and mouse data lines, event pulses from the on-chip keyboard controller, and a bank of general purpose pins. A status bit latches when its source fires. Software clears it by writing a one to it. The wake request goes low while any latched status bit has its enable bit set.

The block has two reset domains. The standby power-on reset clears every status bit, every enable bit and the isolation controls. The main power-on reset clears only the pin directions and the keyboard controller reset bit, so enables and latched events survive the loss of main power. Isolation controls stop the on-chip keyboard controller from setting status. They do not stop the external data lines, which still set status when driven low. A configuration register holds a reset bit for the keyboard controller. That bit stays set until software writes it back to zero. All registers sit behind a small synchronous register port with a 3-bit address and a combinational read.

Top module: `wk_wake_ctrl`

## Requirements
- R1: Register address 0 holds keyboard wake status at bit 3 and mouse wake status at bit 4. Each bit sets while its data line, after a two-flop synchronizer, is low. Address 1 holds the matching enable bits at bits 3 and 4. All other bits of both registers read zero.
- R2: Address 5 bit 0 isolates the keyboard and bit 1 isolates the mouse. An isolated source ignores event pulses from the on-chip controller. A low level on the external data line still sets the bit.
- R3: Writing 1 to a status bit (address 0 or address 2) clears it. Writing 0 leaves it unchanged. If a clear and a new event arrive in the same cycle, the bit stays set.
- R4: `wake_n_o` is a register. It goes low on the cycle after any status bit and its enable bit are both set. It returns high on the cycle after the last such pair stops matching.
- R5: Standby reset clears all status, enable and isolation bits and drives `wake_n_o` high. Main reset clears the pin directions and the keyboard controller reset bit, and leaves status, enables and isolation unchanged.
- R6: There are 13 general purpose pins. Address 4 holds the direction of each pin, bit i for pin i, with 1 meaning input; it resets to 0. After a two-flop synchronizer, a rising or falling edge on an input pin sets bit i of the status register at address 2. A pin set as output sets nothing.
- R7: Address 3 holds one wake enable bit per pin. Pin 12 has no enable: its enable bit always reads 0 and writes to it are ignored. A latched status bit for pin 12 never pulls `wake_n_o` low.
- R8: Address 5 bit 6 drives `kbc_rst_o`. It keeps its value until software writes it again. All other bits of address 5 read zero, apart from the isolation bits. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| stby_rst_n | input | 1 | Standby power-on reset, active low, asynchronous |
| main_rst_n | input | 1 | Main power-on reset, active low, asynchronous |
| kbd_dat_i | input | 1 | Keyboard data line, asynchronous |
| ms_dat_i | input | 1 | Mouse data line, asynchronous |
| kbc_kbd_evt_i | input | 1 | Keyboard event pulse from the on-chip controller |
| kbc_ms_evt_i | input | 1 | Mouse event pulse from the on-chip controller |
| gp_pin_i | input | 13 | General purpose pin levels, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| wake_n_o | output | 1 | Wake request, active low, registered |
| kbc_rst_o | output | 1 | Keyboard controller reset, active high |

## Verification
The hardest case to create is a status clear that lands in the same clock edge as a fresh event. The bench reaches it by driving a write-one-to-clear strobe and an on-chip controller pulse in the same cycle. It also issues a clear while a data line is held low. A second hard case is the one-cycle lag of the wake output after the last clear. The bench samples the output on the first falling edge after the clearing edge and again on the next one. Reset domain separation is checked by pulsing the main reset alone after enables, isolation, direction and status have been loaded. Random pin toggles, line changes and register writes then run against a shadow model.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 16;

  localparam int KBD_BIT     = 3;
  localparam int MS_BIT      = 4;
  localparam int KBD_ISO_BIT = 0;
  localparam int MS_ISO_BIT  = 1;
  localparam int KBC_RST_BIT = 6;

  typedef enum logic [REG_AW-1:0] {
    RA_DEV_ST = 3'd0,
    RA_DEV_EN = 3'd1,
    RA_GP_ST  = 3'd2,
    RA_GP_EN  = 3'd3,
    RA_GP_DIR = 3'd4,
    RA_CFG    = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/wk_rst_sync.sv
module wk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int   W       = 1,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_BIT}};
      sync_q <= {W{RST_BIT}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/wk_dev_bank.sv
module wk_dev_bank (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_dat_i,
  input  logic       ms_dat_i,
  input  logic       kbc_kbd_evt_i,
  input  logic       kbc_ms_evt_i,
  input  logic       iso_kbd_i,
  input  logic       iso_ms_i,
  input  logic       wr_st_i,
  input  logic       wr_en_i,
  input  logic [1:0] wdata_i,
  output logic [1:0] st_o,
  output logic [1:0] en_o,
  output logic       pend_o
);
  logic [1:0] line_s;
  logic [1:0] set_v, clr_v;
  logic [1:0] st_q, st_nxt, en_q, en_nxt;

  wk_sync #(.W(2), .RST_BIT(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ms_dat_i, kbd_dat_i}),
    .q_o   (line_s)
  );

  always_comb begin
    set_v[0] = ~line_s[0] | (kbc_kbd_evt_i & ~iso_kbd_i);
    set_v[1] = ~line_s[1] | (kbc_ms_evt_i & ~iso_ms_i);
    clr_v    = wr_st_i ? wdata_i : 2'b00;
    st_nxt   = (st_q & ~clr_v) | set_v;
    en_nxt   = wr_en_i ? wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 2'b00;
      en_q <= 2'b00;
    end else begin
      st_q <= st_nxt;
      en_q <= en_nxt;
    end
  end

  assign st_o   = st_q;
  assign en_o   = en_q;
  assign pend_o = |(st_q & en_q);

  AST_KBD_LOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    !line_s[0] |=> st_q[0]); // R1
  AST_MS_LOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    !line_s[1] |=> st_q[1]); // R1
  AST_ISO_BLOCKS_KBC: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_kbd_i && line_s[0] && !st_q[0]) |=> !st_q[0]); // R2
  AST_DEV_CLR_WINS_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st_i && wdata_i[0] && kbc_kbd_evt_i && !iso_kbd_i) |=> st_q[0]); // R3
endmodule

// File: rtl/wk_gp_bank.sv
module wk_gp_bank #(
  parameter int GP_N    = 13,
  parameter int GP_EXCL = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_rst_n,
  input  logic [GP_N-1:0] pin_i,
  input  logic            wr_st_i,
  input  logic            wr_en_i,
  input  logic            wr_dir_i,
  input  logic [GP_N-1:0] wdata_i,
  output logic [GP_N-1:0] st_o,
  output logic [GP_N-1:0] en_o,
  output logic [GP_N-1:0] dir_o,
  output logic            pend_o
);
  logic [GP_N-1:0] pin_s, pin_d_q;
  logic [GP_N-1:0] edge_v, set_v, clr_v;
  logic [GP_N-1:0] st_q, st_nxt, dir_q, dir_nxt, en_q;

  wk_sync #(.W(GP_N), .RST_BIT(1'b0)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  always_comb begin
    edge_v  = pin_s ^ pin_d_q;
    set_v   = edge_v & dir_q;
    clr_v   = wr_st_i ? wdata_i : '0;
    st_nxt  = (st_q & ~clr_v) | set_v;
    dir_nxt = wr_dir_i ? wdata_i : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d_q <= '0;
      st_q    <= '0;
    end else begin
      pin_d_q <= pin_s;
      st_q    <= st_nxt;
    end
  end

  always_ff @(posedge clk or negedge main_rst_n) begin
    if (!main_rst_n) dir_q <= '0;
    else             dir_q <= dir_nxt;
  end

  for (genvar i = 0; i < GP_N; i++) begin : g_en
    if (i == GP_EXCL) begin : g_fixed
      assign en_q[i] = 1'b0;
    end else begin : g_bit
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       b_q <= 1'b0;
        else if (wr_en_i) b_q <= wdata_i[i];
      end
      assign en_q[i] = b_q;
    end
  end

  assign st_o   = st_q;
  assign en_o   = en_q;
  assign dir_o  = dir_q;
  assign pend_o = |(st_q & en_q);

  AST_GP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((st_q & $past(set_v)) == $past(set_v))); // R3
  AST_GP_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st_i && set_v == '0) |=> ((st_q & $past(wdata_i)) == '0)); // R3
  AST_OUT_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !main_rst_n)
    1'b1 |=> ((~$past(dir_q) & ~$past(st_q) & st_q) == '0)); // R6
endmodule

// File: rtl/wk_wake_ctrl.sv
module wk_wake_ctrl import wk_pkg::*; #(
  parameter int GP_N    = 13,
  parameter int GP_EXCL = 12
) (
  input  logic              clk,
  input  logic              stby_rst_n,
  input  logic              main_rst_n,
  input  logic              kbd_dat_i,
  input  logic              ms_dat_i,
  input  logic              kbc_kbd_evt_i,
  input  logic              kbc_ms_evt_i,
  input  logic [GP_N-1:0]   gp_pin_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              wake_n_o,
  output logic              kbc_rst_o
);
  logic sb_rst_n, mn_rst_n, mn_raw_n;
  logic wr_dev_st, wr_dev_en, wr_gp_st, wr_gp_en, wr_gp_dir, wr_cfg;
  logic [1:0] dev_st, dev_en, iso_q, iso_nxt;
  logic [GP_N-1:0] gp_st, gp_en, gp_dir;
  logic dev_pend, gp_pend;
  logic kbc_rst_q, kbc_rst_nxt, wake_q, wake_nxt;
  logic unused_wdata;

  assign mn_raw_n = stby_rst_n & main_rst_n;

  wk_rst_sync u_sb_rst (.clk(clk), .arst_n(stby_rst_n), .srst_n(sb_rst_n));
  wk_rst_sync u_mn_rst (.clk(clk), .arst_n(mn_raw_n),   .srst_n(mn_rst_n));

  always_comb begin
    wr_dev_st = reg_wr_i && (reg_addr_i == RA_DEV_ST);
    wr_dev_en = reg_wr_i && (reg_addr_i == RA_DEV_EN);
    wr_gp_st  = reg_wr_i && (reg_addr_i == RA_GP_ST);
    wr_gp_en  = reg_wr_i && (reg_addr_i == RA_GP_EN);
    wr_gp_dir = reg_wr_i && (reg_addr_i == RA_GP_DIR);
    wr_cfg    = reg_wr_i && (reg_addr_i == RA_CFG);
  end

  wk_dev_bank u_dev (
    .clk           (clk),
    .rst_n         (sb_rst_n),
    .kbd_dat_i     (kbd_dat_i),
    .ms_dat_i      (ms_dat_i),
    .kbc_kbd_evt_i (kbc_kbd_evt_i),
    .kbc_ms_evt_i  (kbc_ms_evt_i),
    .iso_kbd_i     (iso_q[0]),
    .iso_ms_i      (iso_q[1]),
    .wr_st_i       (wr_dev_st),
    .wr_en_i       (wr_dev_en),
    .wdata_i       ({reg_wdata_i[MS_BIT], reg_wdata_i[KBD_BIT]}),
    .st_o          (dev_st),
    .en_o          (dev_en),
    .pend_o        (dev_pend)
  );

  wk_gp_bank #(.GP_N(GP_N), .GP_EXCL(GP_EXCL)) u_gp (
    .clk        (clk),
    .rst_n      (sb_rst_n),
    .main_rst_n (mn_rst_n),
    .pin_i      (gp_pin_i),
    .wr_st_i    (wr_gp_st),
    .wr_en_i    (wr_gp_en),
    .wr_dir_i   (wr_gp_dir),
    .wdata_i    (reg_wdata_i[GP_N-1:0]),
    .st_o       (gp_st),
    .en_o       (gp_en),
    .dir_o      (gp_dir),
    .pend_o     (gp_pend)
  );

  always_comb begin
    iso_nxt     = wr_cfg ? {reg_wdata_i[MS_ISO_BIT], reg_wdata_i[KBD_ISO_BIT]} : iso_q;
    kbc_rst_nxt = wr_cfg ? reg_wdata_i[KBC_RST_BIT] : kbc_rst_q;
    wake_nxt    = ~(dev_pend | gp_pend);
  end

  always_ff @(posedge clk or negedge sb_rst_n) begin
    if (!sb_rst_n) begin
      iso_q  <= 2'b00;
      wake_q <= 1'b1;
    end else begin
      iso_q  <= iso_nxt;
      wake_q <= wake_nxt;
    end
  end

  always_ff @(posedge clk or negedge mn_rst_n) begin
    if (!mn_rst_n) kbc_rst_q <= 1'b0;
    else           kbc_rst_q <= kbc_rst_nxt;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      RA_DEV_ST: begin
        reg_rdata_o[KBD_BIT] = dev_st[0];
        reg_rdata_o[MS_BIT]  = dev_st[1];
      end
      RA_DEV_EN: begin
        reg_rdata_o[KBD_BIT] = dev_en[0];
        reg_rdata_o[MS_BIT]  = dev_en[1];
      end
      RA_GP_ST:  reg_rdata_o[GP_N-1:0] = gp_st;
      RA_GP_EN:  reg_rdata_o[GP_N-1:0] = gp_en;
      RA_GP_DIR: reg_rdata_o[GP_N-1:0] = gp_dir;
      RA_CFG: begin
        reg_rdata_o[KBD_ISO_BIT] = iso_q[0];
        reg_rdata_o[MS_ISO_BIT]  = iso_q[1];
        reg_rdata_o[KBC_RST_BIT] = kbc_rst_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign unused_wdata = ^reg_wdata_i;
  assign wake_n_o     = wake_q;
  assign kbc_rst_o    = kbc_rst_q;

  AST_WAKE_ASSERTS: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (dev_pend || gp_pend) |=> !wake_n_o); // R4
  AST_WAKE_RELEASES: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (!wake_n_o && !dev_pend && !gp_pend) |=> wake_n_o); // R4
  AST_EXCL_NO_WAKE: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (gp_st == (GP_N'(1) << GP_EXCL) && (dev_st & dev_en) == 2'b00) |=> wake_n_o); // R7
  AST_KBC_RST_HOLDS: assert property (@(posedge clk) disable iff (!mn_rst_n)
    (kbc_rst_q && !wr_cfg) |=> kbc_rst_q); // R8
  AST_MAIN_RST_KEEPS_EN: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (!mn_rst_n && !wr_dev_en) |=> (dev_en == $past(dev_en))); // R5
endmodule

// File: tb/wk_wake_ctrl_tb.sv
module wk_wake_ctrl_tb_top;
  localparam int GP_N    = 13;
  localparam int GP_EXCL = 12;

  logic clk = 1'b0;
  logic stby_rst_n, main_rst_n;
  logic kbd_dat, ms_dat, kbd_evt, ms_evt;
  logic [GP_N-1:0] pins;
  logic reg_wr;
  logic [2:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic wake_n, kbc_rst;

  int checks = 0;
  int errors = 0;

  logic [1:0]      m_dev_st, m_dev_en, m_iso;
  logic [GP_N-1:0] m_gp_st, m_gp_en, m_dir;
  logic            m_kbc;

  always #5 clk = ~clk;

  wk_wake_ctrl #(.GP_N(GP_N), .GP_EXCL(GP_EXCL)) dut_i (
    .clk           (clk),
    .stby_rst_n    (stby_rst_n),
    .main_rst_n    (main_rst_n),
    .kbd_dat_i     (kbd_dat),
    .ms_dat_i      (ms_dat),
    .kbc_kbd_evt_i (kbd_evt),
    .kbc_ms_evt_i  (ms_evt),
    .gp_pin_i      (pins),
    .reg_wr_i      (reg_wr),
    .reg_addr_i    (reg_addr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .wake_n_o      (wake_n),
    .kbc_rst_o     (kbc_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_reg(input int a);
    logic [15:0] v = '0;
    case (a)
      0: begin v[3] = m_dev_st[0]; v[4] = m_dev_st[1]; end
      1: begin v[3] = m_dev_en[0]; v[4] = m_dev_en[1]; end
      2: v[GP_N-1:0] = m_gp_st;
      3: v[GP_N-1:0] = m_gp_en;
      4: v[GP_N-1:0] = m_dir;
      5: begin v[0] = m_iso[0]; v[1] = m_iso[1]; v[6] = m_kbc; end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic exp_wake();
    return ~(|(m_dev_st & m_dev_en) | |(m_gp_st & m_gp_en));
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0, 1: return "R1";
      2, 4: return "R6";
      3:    return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic void model_lines();
    if (!kbd_dat) m_dev_st[0] = 1'b1;
    if (!ms_dat)  m_dev_st[1] = 1'b1;
  endfunction

  function automatic void model_write(input int a, input logic [15:0] d);
    case (a)
      0: m_dev_st = m_dev_st & ~{d[4], d[3]};
      1: m_dev_en = {d[4], d[3]};
      2: m_gp_st  = m_gp_st & ~d[GP_N-1:0];
      3: begin m_gp_en = d[GP_N-1:0]; m_gp_en[GP_EXCL] = 1'b0; end
      4: m_dir    = d[GP_N-1:0];
      5: begin m_iso = d[1:0]; m_kbc = d[6]; end
      default: ;
    endcase
    model_lines();
  endfunction

  task automatic settle(input int n = 6);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    reg_addr = 3'(a);
    #1;
    v = reg_rdata;
  endtask

  task automatic check_all();
    logic [15:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk(req_of(a), 32'(v), 32'(exp_reg(a)));
    end
    chk("R4", 32'(wake_n), 32'(exp_wake()));
    chk("R8", 32'(kbc_rst), 32'(m_kbc));
  endtask

  task automatic toggle_pin(input int i);
    @(negedge clk);
    pins[i] = ~pins[i];
    if (m_dir[i]) m_gp_st[i] = 1'b1;
    settle();
  endtask

  task automatic pulse_evt(input int which);
    @(negedge clk);
    if (which == 0) kbd_evt = 1'b1; else ms_evt = 1'b1;
    @(negedge clk);
    kbd_evt = 1'b0; ms_evt = 1'b0;
    if (!m_iso[which]) m_dev_st[which] = 1'b1;
  endtask

  task automatic stby_reset();
    @(negedge clk);
    stby_rst_n = 1'b0; main_rst_n = 1'b0;
    settle(3);
    stby_rst_n = 1'b1; main_rst_n = 1'b1;
    m_dev_st = '0; m_dev_en = '0; m_iso = '0;
    m_gp_st = '0; m_gp_en = '0; m_dir = '0; m_kbc = 1'b0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h00C0FFEE));
    stby_rst_n = 1'b0; main_rst_n = 1'b0;
    kbd_dat = 1'b1; ms_dat = 1'b1; kbd_evt = 1'b0; ms_evt = 1'b0;
    pins = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    stby_reset();
    check_all(); // R5 reset state

    // R1: low data lines latch status
    @(negedge clk); kbd_dat = 1'b0; model_lines(); settle();
    rd(0, v); chk("R1", 32'(v), 32'h08);
    @(negedge clk); ms_dat = 1'b0; model_lines(); settle();
    rd(0, v); chk("R1", 32'(v), 32'h18);

    // R3: write 0 keeps, clear while line low keeps, clear after release clears
    wr(0, 16'h0000); settle(2); rd(0, v); chk("R3", 32'(v), 32'h18);
    wr(0, 16'h0018); settle(2); rd(0, v); chk("R3", 32'(v), 32'h18);
    @(negedge clk); kbd_dat = 1'b1; ms_dat = 1'b1; settle();
    wr(0, 16'h0008); settle(2); rd(0, v); chk("R3", 32'(v), 32'h10);
    wr(0, 16'h0010); settle(2); rd(0, v); chk("R3", 32'(v), 32'h00);

    // R2: isolation blocks controller pulses, not the external line
    wr(5, 16'h0003);
    pulse_evt(0); pulse_evt(1); settle();
    rd(0, v); chk("R2", 32'(v), 32'h00);
    @(negedge clk); kbd_dat = 1'b0; model_lines(); settle();
    @(negedge clk); kbd_dat = 1'b1; settle();
    rd(0, v); chk("R2", 32'(v), 32'h08);
    wr(0, 16'h0018); wr(5, 16'h0000);
    pulse_evt(1); settle();
    rd(0, v); chk("R2", 32'(v), 32'h10);

    // R3: clear and controller event in the same cycle -> bit stays set
    wr(0, 16'h0018); settle(2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0008; kbd_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; kbd_evt = 1'b0;
    m_dev_st = 2'b01;
    rd(0, v); chk("R3", 32'(v), 32'h08);

    // R4: wake follows status & enable, releases one cycle after the clear
    wr(1, 16'h0008); settle(2);
    chk("R4", 32'(wake_n), 32'd0);
    wr(0, 16'h0008);
    rd(0, v); chk("R3", 32'(v), 32'h00);
    chk("R4", 32'(wake_n), 32'd0);
    @(negedge clk);
    chk("R4", 32'(wake_n), 32'd1);

    // R6: either edge on input pin, none on output pin
    wr(4, 16'h0020);
    toggle_pin(5); rd(2, v); chk("R6", 32'(v), 32'h0020);
    wr(2, 16'h0020);
    toggle_pin(5); rd(2, v); chk("R6", 32'(v), 32'h0020);
    wr(2, 16'h0020);
    toggle_pin(7); toggle_pin(7); rd(2, v); chk("R6", 32'(v), 32'h0000);

    // R7: excluded pin has no enable and never wakes
    wr(3, 16'h1FFF); rd(3, v); chk("R7", 32'(v), 32'h0FFF);
    wr(4, 16'h1000); toggle_pin(GP_EXCL);
    rd(2, v); chk("R7", 32'(v), 32'h1000);
    chk("R7", 32'(wake_n), 32'd1);
    wr(2, 16'h1000); wr(3, 16'h0000);

    // R8: controller reset bit holds until rewritten
    wr(5, 16'h0040); settle(10);
    chk("R8", 32'(kbc_rst), 32'd1);
    wr(5, 16'h0000); settle(2);
    chk("R8", 32'(kbc_rst), 32'd0);

    // R5: main reset alone keeps standby state
    wr(1, 16'h0018); wr(3, 16'h0003); wr(5, 16'h0041); wr(4, 16'h0003);
    toggle_pin(0);
    @(negedge clk); main_rst_n = 1'b0; settle(3); main_rst_n = 1'b1;
    m_dir = '0; m_kbc = 1'b0; settle();
    check_all();
    stby_reset(); check_all(); // R5 standby clears all

    // random phase
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0, 1: toggle_pin(int'($urandom_range(0, GP_N - 1)));
        2: begin
          int a;
          a = int'($urandom_range(0, 7));
          wr(a, 16'($urandom));
          settle();
        end
        3: begin pulse_evt(int'($urandom_range(0, 1))); settle(); end
        4: begin
          @(negedge clk);
          kbd_dat = ($urandom_range(0, 3) != 0);
          ms_dat  = ($urandom_range(0, 3) != 0);
          model_lines();
          settle();
        end
        default: begin
          @(negedge clk); main_rst_n = 1'b0; settle(2); main_rst_n = 1'b1;
          m_dir = '0; m_kbc = 1'b0; settle();
        end
      endcase
      check_all();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule